// File: doc/BRIEF.md
# VID Transition Slew Stepper

This block sits between the processor's parallel voltage-identification pins and the reference DAC of a multiphase regulator. It lets the processor change the requested code while the regulator is running. Bit changes on the input do not all arrive at once, so a new code is taken only after it has stayed unchanged for a programmable skew window. The code driven to the DAC then moves toward the accepted target one LSB at a time, one step per fixed step period. A full jump and a bit-by-bit walk therefore slew at the same rate.

While the applied code is moving, a busy flag is held high so that the power-good supervisor can ignore out-of-window faults. After reset the first accepted code is loaded directly, with no slewing. A target accepted in the middle of a transition redirects the walk from wherever the applied code stands, and the step cadence carries on without a restart. Both window lengths are counts of clock cycles: at 250 MHz, 100 cycles give 400 ns and 500 cycles give 2 µs. The mapping from LSB to millivolts belongs to the DAC and is not handled here.

Top module: `vid_slew_stepper`

## Requirements
- R1: While reset is asserted and right after it is released, `dac_code_o` is 0 and `slew_busy_o` is 0.
- R2: A value on `vid_i` is accepted only when it has been sampled unchanged on SKEW_CYC+1 consecutive rising edges. Acceptance takes effect on the last of those edges. Any change restarts the count, so a value held for only SKEW_CYC edges is never accepted.
- R3: The first code accepted after reset is copied straight into `dac_code_o` on the acceptance edge, and `slew_busy_o` stays 0.
- R4: When a later accepted code differs from `dac_code_o`, `slew_busy_o` rises one cycle after the acceptance edge.
- R5: Each change of `dac_code_o` after the first load is exactly +1 or −1. The direction comes from an unsigned comparison of target and applied code. The applied code never passes the target and never wraps.
- R6: The first step comes STEP_CYC+1 cycles after acceptance, and each later step follows STEP_CYC cycles after the one before. A jump of N codes therefore holds `slew_busy_o` high for exactly N·STEP_CYC+1 cycles.
- R7: A new target accepted mid-transition keeps the existing step cadence, with no timer restart, and the walk turns toward the new target.
- R8: `slew_busy_o` stays high for the whole transition and falls one cycle after `dac_code_o` equals the target. `dac_code_o` changes only while `slew_busy_o` is high.
- R9: An input glitch shorter than the skew window leaves `dac_code_o` and `slew_busy_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vid_i | input | VID_W | Raw requested code from the processor |
| dac_code_o | output | VID_W | Code applied to the reference DAC |
| slew_busy_o | output | 1 | High while a transition is in progress (power-good blanking) |

## Verification
A corrupted skew counter shows up as the busy flag rising too early after a short glitch, or one cycle late after a valid change. Either way the mismatch appears at the ports within SKEW_CYC+2 cycles of the input edge. A step timer that has lost its phase moves `dac_code_o` off the expected cadence, which is visible at the very next step, no more than STEP_CYC cycles later. A wrong target or direction produces a step the wrong way or a busy flag that never falls. The per-cycle model comparison catches either case on the first cycle the output diverges.

// File: rtl/vid_step_pkg.sv
package vid_step_pkg;

  localparam int unsigned MAX_CODE_W = 16;

  typedef enum logic [1:0] {
    DIR_HOLD = 2'b00,
    DIR_UP   = 2'b01,
    DIR_DOWN = 2'b10
  } step_dir_e;

  // Unsigned comparison picks which way the applied code must move.
  function automatic step_dir_e pick_dir(input logic [MAX_CODE_W-1:0] cur,
                                         input logic [MAX_CODE_W-1:0] goal);
    step_dir_e d;
    if (goal > cur)      d = DIR_UP;
    else if (goal < cur) d = DIR_DOWN;
    else                 d = DIR_HOLD;
    return d;
  endfunction

endpackage

// File: rtl/vid_skew_filter.sv
module vid_skew_filter #(
  parameter int unsigned VID_W    = 8,
  parameter int unsigned SKEW_CYC = 100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VID_W-1:0] vid_i,
  output logic             acc_o,
  output logic [VID_W-1:0] acc_code_o
);

  localparam int unsigned CW = $clog2(SKEW_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(SKEW_CYC - 1);
  localparam logic [CW-1:0] CNT_DONE = CW'(SKEW_CYC);

  logic [VID_W-1:0] smp_q, smp_n;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic             same;
  logic             cnt_en;

  assign same = (vid_i == smp_q);

  always_comb begin
    smp_n  = smp_q;
    cnt_n  = cnt_q;
    cnt_en = 1'b0;
    if (!same) begin
      smp_n  = vid_i;
      cnt_n  = '0;
      cnt_en = 1'b1;
    end else if (cnt_q != CNT_DONE) begin
      cnt_n  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q <= '0;
      cnt_q <= '0;
    end else if (cnt_en) begin
      smp_q <= smp_n;
      cnt_q <= cnt_n;
    end
  end

  assign acc_o      = same && (cnt_q == CNT_LAST);
  assign acc_code_o = smp_q;

endmodule

// File: rtl/vid_step_timer.sv
module vid_step_timer #(
  parameter int unsigned STEP_CYC = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);

  localparam int unsigned TW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam logic [TW-1:0] TMR_LAST = TW'(STEP_CYC - 1);

  logic [TW-1:0] tmr_q, tmr_n;
  logic          wrap;

  assign wrap = (tmr_q == TMR_LAST);

  always_comb begin
    if (!run_i)    tmr_n = '0;
    else if (wrap) tmr_n = '0;
    else           tmr_n = tmr_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tmr_q <= '0;
    else         tmr_q <= tmr_n;
  end

  assign tick_o = run_i && wrap;

endmodule

// File: rtl/vid_code_walker.sv
module vid_code_walker
  import vid_step_pkg::*;
#(
  parameter int unsigned VID_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic [VID_W-1:0] acc_code_i,
  input  logic             tick_i,
  output logic [VID_W-1:0] app_o,
  output logic [VID_W-1:0] tgt_o,
  output logic             busy_o,
  output logic             seeded_o
);

  logic [VID_W-1:0] app_q, app_n;
  logic [VID_W-1:0] tgt_q, tgt_n;
  logic             busy_q, busy_n;
  logic             seeded_q, seeded_n;
  logic             upd_en;
  step_dir_e        dir;

  always_comb begin
    tgt_n    = acc_i ? acc_code_i : tgt_q;
    app_n    = app_q;
    seeded_n = seeded_q;
    dir      = pick_dir(MAX_CODE_W'(app_q), MAX_CODE_W'(tgt_n));
    if (acc_i && !seeded_q) begin
      app_n    = acc_code_i;
      seeded_n = 1'b1;
    end else if (tick_i) begin
      case (dir)
        DIR_UP:   app_n = app_q + 1'b1;
        DIR_DOWN: app_n = app_q - 1'b1;
        default:  app_n = app_q;
      endcase
    end
    busy_n = seeded_q && (app_q != tgt_q);
    upd_en = acc_i || tick_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      app_q    <= '0;
      tgt_q    <= '0;
      seeded_q <= 1'b0;
    end else if (upd_en) begin
      app_q    <= app_n;
      tgt_q    <= tgt_n;
      seeded_q <= seeded_n;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= 1'b0;
    else         busy_q <= busy_n;
  end

  assign app_o    = app_q;
  assign tgt_o    = tgt_q;
  assign busy_o   = busy_q;
  assign seeded_o = seeded_q;

endmodule

// File: rtl/vid_slew_stepper.sv
module vid_slew_stepper #(
  parameter int unsigned VID_W    = 8,
  parameter int unsigned SKEW_CYC = 100,
  parameter int unsigned STEP_CYC = 500
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VID_W-1:0] vid_i,
  output logic [VID_W-1:0] dac_code_o,
  output logic             slew_busy_o
);

  logic             acc;
  logic [VID_W-1:0] acc_code;
  logic             tick;
  logic [VID_W-1:0] tgt_code;
  logic             seeded;
  logic             busy;

  vid_skew_filter #(
    .VID_W   (VID_W),
    .SKEW_CYC(SKEW_CYC)
  ) u_filter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vid_i     (vid_i),
    .acc_o     (acc),
    .acc_code_o(acc_code)
  );

  vid_step_timer #(
    .STEP_CYC(STEP_CYC)
  ) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (busy),
    .tick_o(tick)
  );

  vid_code_walker #(
    .VID_W(VID_W)
  ) u_walker (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acc_i     (acc),
    .acc_code_i(acc_code),
    .tick_i    (tick),
    .app_o     (dac_code_o),
    .tgt_o     (tgt_code),
    .busy_o    (busy),
    .seeded_o  (seeded)
  );

  assign slew_busy_o = busy;

endmodule

// File: rtl/vid_slew_stepper_chk.sv
module vid_slew_stepper_chk #(
  parameter int unsigned VID_W    = 8,
  parameter int unsigned STEP_CYC = 500
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [VID_W-1:0] vid_i,
  input logic [VID_W-1:0] dac_code_o,
  input logic             slew_busy_o,
  input logic [VID_W-1:0] tgt_q,
  input logic             seeded_q
);

  localparam int unsigned GW = $clog2(STEP_CYC + 1);
  localparam logic [GW-1:0] GAP_SAT = GW'(STEP_CYC);
  localparam logic [GW-1:0] GAP_MIN = GW'(STEP_CYC - 1);

  logic [VID_W-1:0] dac_d, tgt_d, vid_d;
  logic             seeded_d, busy_d;
  logic [GW-1:0]    gap_q;
  logic             chg;

  assign chg = (dac_code_o != dac_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dac_d    <= '0;
      tgt_d    <= '0;
      vid_d    <= '0;
      seeded_d <= 1'b0;
      busy_d   <= 1'b0;
      gap_q    <= GAP_SAT;
    end else begin
      dac_d    <= dac_code_o;
      tgt_d    <= tgt_q;
      vid_d    <= vid_i;
      seeded_d <= seeded_q;
      busy_d   <= slew_busy_o;
      if (chg)                 gap_q <= '0;
      else if (gap_q != GAP_SAT) gap_q <= gap_q + 1'b1;
    end
  end

  p_unseeded_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seeded_q |-> (!slew_busy_o && dac_code_o == '0));

  p_target_from_input_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_q != tgt_d) |-> (vid_d == tgt_q));

  p_unit_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seeded_d && chg) |->
      (({1'b0, dac_code_o}) == ({1'b0, dac_d} + 1'b1) ||
       ({1'b0, dac_d})      == ({1'b0, dac_code_o} + 1'b1)));

  p_no_overshoot_up_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seeded_d && chg && dac_code_o > dac_d) |-> (dac_code_o <= tgt_q));

  p_no_overshoot_down_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seeded_d && chg && dac_code_o < dac_d) |-> (dac_code_o >= tgt_q));

  p_step_spacing_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seeded_d && chg) |-> (gap_q >= GAP_MIN));

  p_move_only_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seeded_d && chg) |-> busy_d);

  p_busy_while_apart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dac_d != tgt_d) |-> slew_busy_o);

endmodule

bind vid_slew_stepper vid_slew_stepper_chk #(
  .VID_W   (VID_W),
  .STEP_CYC(STEP_CYC)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .vid_i      (vid_i),
  .dac_code_o (dac_code_o),
  .slew_busy_o(slew_busy_o),
  .tgt_q      (tgt_code),
  .seeded_q   (seeded)
);

// File: tb/vid_slew_stepper_tb_top.sv
module vid_slew_stepper_tb_top;

  localparam int VW   = 8;
  localparam int SKEW = 4;
  localparam int STEP = 6;

  logic          clk;
  logic          rst_n;
  logic [VW-1:0] vid;
  logic [VW-1:0] dac;
  logic          busy;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 0;

  // Reference model state
  int m_raw, m_stab, m_tgt, m_app;
  bit m_seed, m_busy;
  int m_phase;

  // Change log for cadence checking
  int chg_t[$];
  logic [VW-1:0] dac_prev;

  vid_slew_stepper #(
    .VID_W   (VW),
    .SKEW_CYC(SKEW),
    .STEP_CYC(STEP)
  ) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .vid_i      (vid),
    .dac_code_o (dac),
    .slew_busy_o(busy)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Behavioural reference model, updated on each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_raw = 0; m_stab = 0; m_tgt = 0; m_app = 0;
      m_seed = 0; m_busy = 0; m_phase = 0;
    end else begin
      bit acc, stp, nb;
      int nt;
      acc = 0;
      if (int'(vid) != m_raw) begin
        m_raw = int'(vid);
        m_stab = 0;
      end else if (m_stab < SKEW) begin
        m_stab++;
        if (m_stab == SKEW) acc = 1;
      end
      nt  = acc ? int'(vid) : m_tgt;
      stp = m_busy && (m_phase == STEP - 1);
      nb  = m_seed && (m_app != m_tgt);
      if (m_busy) m_phase = (m_phase == STEP - 1) ? 0 : m_phase + 1;
      else        m_phase = 0;
      if (acc && !m_seed) begin
        m_app = int'(vid); m_tgt = int'(vid); m_seed = 1;
      end else begin
        m_tgt = nt;
        if (stp && m_app != nt) m_app = (nt > m_app) ? m_app + 1 : m_app - 1;
      end
      m_busy = nb;
    end
  end

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check("R5 dac vs model", int'(dac), m_app);
      check("R8 busy vs model", int'(busy), int'(m_busy));
      if (dac != dac_prev) chg_t.push_back(cyc);
    end
    dac_prev = dac;
  end

  // Drive a code and measure cycles to first busy and busy-high length
  task automatic run_to(input logic [VW-1:0] code, output int rise, output int hi);
    bit started;
    started = 0; rise = 0; hi = 0;
    vid = code;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (busy) begin
        if (!started) rise = i + 1;
        started = 1;
        hi++;
      end else if (started) begin
        break;
      end else if (i > SKEW + 6) begin
        break;
      end
    end
  endtask

  initial begin
    int rise, hi, n0;
    bit ok;
    rst_n = 1'b0;
    vid = '0;
    dac_prev = '0;
    repeat (3) @(negedge clk);
    check("R1 reset dac", int'(dac), 0);
    check("R1 reset busy", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 post-reset dac", int'(dac), 0);

    // R3: first accepted code loads directly
    vid = 8'h40;
    repeat (SKEW + 4) @(negedge clk);
    check("R3 seed dac", int'(dac), 'h40);
    check("R3 seed busy", int'(busy), 0);

    // R9: short glitch ignored
    vid = 8'h41;
    repeat (2) @(negedge clk);
    vid = 8'h40;
    repeat (SKEW + 6) @(negedge clk);
    check("R9 glitch dac", int'(dac), 'h40);
    check("R9 glitch busy", int'(busy), 0);

    // R2: held for exactly SKEW edges is not accepted
    vid = 8'h44;
    repeat (SKEW) @(negedge clk);
    vid = 8'h40;
    repeat (SKEW + 6) @(negedge clk);
    check("R2 boundary busy", int'(busy), 0);
    check("R2 boundary dac", int'(dac), 'h40);

    // Skewed bit arrival then a jump of 7 codes
    vid = 8'h43;
    @(negedge clk);
    run_to(8'h47, rise, hi);
    check("R4 busy rise latency", rise, SKEW + 2);
    check("R6 jump of 7 busy length", hi, 7 * STEP + 1);
    check("R5 final up", int'(dac), 'h47);

    // Single step
    run_to(8'h48, rise, hi);
    check("R6 single step busy length", hi, STEP + 1);

    // Downward jump
    run_to(8'h44, rise, hi);
    check("R5 final down", int'(dac), 'h44);
    check("R6 down busy length", hi, 4 * STEP + 1);

    // R7: retarget mid-transition, cadence kept
    vid = 8'h50;
    while (dac != 8'h49) @(negedge clk);
    n0 = chg_t.size() - 2;
    vid = 8'h46;
    for (int i = 0; i < 2000 && !(dac == 8'h46 && !busy); i++) @(negedge clk);
    check("R7 retarget final", int'(dac), 'h46);
    ok = 1;
    for (int i = n0 + 1; i < chg_t.size(); i++)
      if (chg_t[i] - chg_t[i-1] != STEP) ok = 0;
    check("R7 cadence kept across retarget", int'(ok), 1);

    // Gradual walk, one code at a time
    for (int k = 1; k <= 4; k++) begin
      vid = 8'h46 + VW'(k);
      repeat (SKEW + 3) @(negedge clk);
    end
    for (int i = 0; i < 500 && busy; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    check("R5 gradual final", int'(dac), 'h4A);

    // Extremes: no wrap
    run_to(8'h00, rise, hi);
    check("R5 floor", int'(dac), 0);
    run_to(8'hFF, rise, hi);
    check("R5 ceiling", int'(dac), 'hFF);
    check("R8 idle at ceiling", int'(busy), 0);

    done = 1;
  end

  initial begin
    while (!done && cyc < 100000) @(negedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=finish before 100000 cycles", cyc);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule